// File: doc/BRIEF.md
# Bounded sharer record with pointer and coarse-group forms

This block keeps the sharer record for a single directory entry when the system has more cores than the record has bits. A fixed-width body is read in one of two ways. While few cores share the line, it holds their exact indices as pointer slots. When one more distinct sharer arrives than there are free slots, the body is rewritten as a coarse vector in which each bit stands for a run of consecutive cores.

Commands arrive one per cycle: add a sharer, clear the record, or expand it into a full per-core invalidation mask. The expanded mask always covers every real sharer. It names exactly the sharers while the record is in pointer form, and names whole groups once it has gone coarse. When the core count fits inside the record width, a plain one-bit-per-core vector is built in its place. That form is always exact.

Top module: `shr_rec_enc`

## Requirements
- R1: After reset the record is empty. An expand then returns an all-zero mask with `exp_exact` high, and `exp_valid` is low until the first expand.
- R2: An expand command on `cmd_op` (encoding 2'b11) raises `exp_valid` for exactly the following cycle and loads `exp_mask`/`exp_exact` at that edge. Any other command leaves `exp_mask` unchanged. Add is 2'b01, clear is 2'b10 and idle is 2'b00.
- R3: In pointer form (default: up to 5 slots for 64 cores) the expanded mask has bit c set exactly for each distinct core c added since the last clear, and `exp_exact` is high.
- R4: Adding a core that is already held as a pointer takes no slot. Repeated adds of one core followed by four other distinct cores still expand exactly.
- R5: Adding a sixth distinct core while all slots are full converts the record to coarse form in that cycle. The next expand marks every core whose group of 4 consecutive cores (group = core/4) contains an earlier pointer or the new core, and `exp_exact` is low.
- R6: In coarse form an add sets the group bit of that core. An add to a group already set leaves the expanded mask unchanged, and the record stays coarse until a clear.
- R7: Every expanded mask is a superset of the true sharer set, and while `exp_exact` is high it has no more set bits than there are pointer slots.
- R8: A clear returns the record to empty pointer form. Later adds are again tracked exactly.
- R9: When NUM_CORES is no larger than the record width, the block keeps one bit per core and every expand is exact, for any number of sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 00 idle, 01 add, 10 clear, 11 expand |
| cmd_core | input | $clog2(NUM_CORES) | Core index for an add |
| exp_valid | output | 1 | High for the cycle after an expand |
| exp_mask | output | NUM_CORES | Cores to invalidate, loaded on expand |
| exp_exact | output | 1 | Mask equals the sharer set, so its bit count is a true sharer count |

## Verification
A wrong slot count or a missed duplicate match shows at the next expand. The mask then loses a sharer, or the record converts early, so `exp_exact` drops while fewer than six cores were added. A bad conversion shows as a group missing from the first coarse mask, one cycle after the expand is issued. Because the bench's reference tracks the true set and its group closure, every expand compares both the exact mask and the superset property, so a corrupted record body cannot hide for longer than one expand.

// File: rtl/shr_pkg.sv
package shr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_ADD  = 2'b01,
      OP_CLR  = 2'b10,
      OP_EXP  = 2'b11
   } shr_op_e;

   typedef enum logic [1:0] {
      MD_PTR = 2'b00,
      MD_CRS = 2'b01
   } shr_mode_e;

   localparam int MODE_W = 2;
endpackage

// File: rtl/shr_ptr_store.sv
module shr_ptr_store
   import shr_pkg::*;
#(
   parameter int NUM_CORES = 64,
   parameter int PTR_W     = 6,
   parameter int NUM_PTR   = 5,
   parameter int CNT_W     = 3,
   parameter int BODY_W    = 30,
   parameter int CRS_W     = 16,
   parameter int GRP_LG    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_i,
   input  logic [PTR_W-1:0]  core_i,
   output shr_mode_e         mode_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [BODY_W-1:0] body_o
);
   localparam int CIDX_W = $clog2(CRS_W);

   shr_mode_e         mode_q, mode_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [BODY_W-1:0] body_q, body_n;
   logic              hit;
   logic [CRS_W-1:0]  own_grp;
   logic [CRS_W-1:0]  spread;

   function automatic logic [CIDX_W-1:0] grp_of(input logic [PTR_W-1:0] c);
      grp_of = CIDX_W'(c >> GRP_LG);
   endfunction

   // duplicate match and group closure of the current slots
   always_comb begin
      hit     = 1'b0;
      own_grp = '0;
      own_grp[grp_of(core_i)] = 1'b1;
      spread  = own_grp;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (CNT_W'(i) < cnt_q && body_q[i*PTR_W +: PTR_W] == core_i)
            hit = 1'b1;
         spread[grp_of(body_q[i*PTR_W +: PTR_W])] = 1'b1;
      end
   end

   always_comb begin
      mode_n = mode_q;
      cnt_n  = cnt_q;
      body_n = body_q;
      case (shr_op_e'(op_i))
         OP_ADD: begin
            if (mode_q == MD_CRS) begin
               body_n = body_q | BODY_W'(own_grp);
            end else if (!hit) begin
               if (cnt_q < CNT_W'(NUM_PTR)) begin
                  for (int i = 0; i < NUM_PTR; i++)
                     if (CNT_W'(i) == cnt_q) body_n[i*PTR_W +: PTR_W] = core_i;
                  cnt_n = cnt_q + 1'b1;
               end else begin
                  mode_n = MD_CRS;
                  body_n = BODY_W'(spread);
               end
            end
         end
         OP_CLR: begin
            mode_n = MD_PTR;
            cnt_n  = '0;
            body_n = '0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_PTR;
         cnt_q  <= '0;
         body_q <= '0;
      end else begin
         mode_q <= mode_n;
         cnt_q  <= cnt_n;
         body_q <= body_n;
      end
   end

   assign mode_o = mode_q;
   assign cnt_o  = cnt_q;
   assign body_o = body_q;

   // R3
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(NUM_PTR));

   // R4
   dup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ADD && mode_q == MD_PTR && hit) |=> ($stable(cnt_q) && $stable(body_q)));

   // R5
   ovf_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ADD && mode_q == MD_PTR && !hit && cnt_q == CNT_W'(NUM_PTR))
      |=> mode_q == MD_CRS);

   // R6
   crs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_CRS && op_i != OP_CLR) |=> mode_q == MD_CRS);

   // R8
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_CLR |=> (mode_q == MD_PTR && cnt_q == '0));
endmodule

// File: rtl/shr_expand.sv
module shr_expand
   import shr_pkg::*;
#(
   parameter int NUM_CORES = 64,
   parameter int PTR_W     = 6,
   parameter int NUM_PTR   = 5,
   parameter int CNT_W     = 3,
   parameter int BODY_W    = 30,
   parameter int GRP_LG    = 2
) (
   input  shr_mode_e             mode_i,
   input  logic [CNT_W-1:0]      cnt_i,
   input  logic [BODY_W-1:0]     body_i,
   output logic [NUM_CORES-1:0]  mask_o,
   output logic                  exact_o
);
   always_comb begin
      mask_o = '0;
      if (mode_i == MD_CRS) begin
         for (int c = 0; c < NUM_CORES; c++)
            mask_o[c] = body_i[c >> GRP_LG];
      end else begin
         for (int i = 0; i < NUM_PTR; i++)
            if (CNT_W'(i) < cnt_i)
               mask_o[body_i[i*PTR_W +: PTR_W]] = 1'b1;
      end
   end

   assign exact_o = (mode_i != MD_CRS);
endmodule

// File: rtl/shr_vec_store.sv
module shr_vec_store
   import shr_pkg::*;
#(
   parameter int NUM_CORES = 16,
   parameter int PTR_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           op_i,
   input  logic [PTR_W-1:0]     core_i,
   output logic [NUM_CORES-1:0] mask_o
);
   logic [NUM_CORES-1:0] vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         vec_q <= '0;
      else if (op_i == OP_CLR)
         vec_q <= '0;
      else if (op_i == OP_ADD)
         vec_q[core_i] <= 1'b1;
   end

   assign mask_o = vec_q;

   // R9
   vec_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_CLR |=> vec_q == '0);

   // R9
   vec_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_ADD |=> vec_q[$past(core_i)]);
endmodule

// File: rtl/shr_rec_enc.sv
module shr_rec_enc
   import shr_pkg::*;
#(
   parameter int NUM_CORES = 64,
   parameter int REC_W     = 32,
   parameter int CRS_W     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    cmd_op,
   input  logic [$clog2(NUM_CORES)-1:0]  cmd_core,
   output logic                          exp_valid,
   output logic [NUM_CORES-1:0]          exp_mask,
   output logic                          exp_exact
);
   localparam int PTR_W   = $clog2(NUM_CORES);
   localparam int BODY_W  = REC_W - MODE_W;
   localparam int NUM_PTR = BODY_W / PTR_W;
   localparam int CNT_W   = $clog2(NUM_PTR + 1);
   localparam int GRP_SZ  = NUM_CORES / CRS_W;
   localparam int GRP_LG  = $clog2(GRP_SZ);
   localparam bit USE_VEC = (NUM_CORES <= REC_W);

   logic [NUM_CORES-1:0] mask_c;
   logic                 exact_c;

   if ((1 << PTR_W) != NUM_CORES || NUM_CORES < 2) begin : g_bad_cores
      $error("NUM_CORES must be a power of two of at least 2");
   end

   if (USE_VEC) begin : g_vec
      shr_vec_store #(
         .NUM_CORES (NUM_CORES),
         .PTR_W     (PTR_W)
      ) u_vec (
         .clk    (clk),
         .rst_n  (rst_n),
         .op_i   (cmd_op),
         .core_i (cmd_core),
         .mask_o (mask_c)
      );
      assign exact_c = 1'b1;
   end else begin : g_wide
      shr_mode_e         mode_w;
      logic [CNT_W-1:0]  cnt_w;
      logic [BODY_W-1:0] body_w;

      if (NUM_PTR < 1) begin : g_bad_ptr
         $error("record too narrow for one pointer");
      end
      if (CRS_W < 2 || CRS_W > BODY_W || (1 << $clog2(CRS_W)) != CRS_W
          || GRP_SZ * CRS_W != NUM_CORES) begin : g_bad_crs
         $error("CRS_W must be a power of two dividing NUM_CORES and fit the record");
      end

      shr_ptr_store #(
         .NUM_CORES (NUM_CORES),
         .PTR_W     (PTR_W),
         .NUM_PTR   (NUM_PTR),
         .CNT_W     (CNT_W),
         .BODY_W    (BODY_W),
         .CRS_W     (CRS_W),
         .GRP_LG    (GRP_LG)
      ) u_store (
         .clk    (clk),
         .rst_n  (rst_n),
         .op_i   (cmd_op),
         .core_i (cmd_core),
         .mode_o (mode_w),
         .cnt_o  (cnt_w),
         .body_o (body_w)
      );

      shr_expand #(
         .NUM_CORES (NUM_CORES),
         .PTR_W     (PTR_W),
         .NUM_PTR   (NUM_PTR),
         .CNT_W     (CNT_W),
         .BODY_W    (BODY_W),
         .GRP_LG    (GRP_LG)
      ) u_expand (
         .mode_i  (mode_w),
         .cnt_i   (cnt_w),
         .body_i  (body_w),
         .mask_o  (mask_c),
         .exact_o (exact_c)
      );

      // R7
      ptr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (exp_valid && exp_exact) |-> $countones(exp_mask) <= NUM_PTR);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_valid <= 1'b0;
         exp_mask  <= '0;
         exp_exact <= 1'b1;
      end else begin
         exp_valid <= (cmd_op == OP_EXP);
         if (cmd_op == OP_EXP) begin
            exp_mask  <= mask_c;
            exp_exact <= exact_c;
         end
      end
   end

   // R2
   exp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid |-> $past(cmd_op) == OP_EXP);

   // R2
   exp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op == OP_EXP |=> exp_valid);

   // R2
   exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op != OP_EXP |=> $stable(exp_mask));
endmodule

// File: tb/shr_rec_enc_test.sv
module shr_rec_enc_test;
   localparam int NC  = 64;
   localparam int NP  = 5;
   localparam int GS  = 4;
   localparam int NC2 = 16;
   localparam int NROW = 20;

   localparam logic [1:0] I_ = 2'b00, AD = 2'b01, CL = 2'b10, EX = 2'b11;

   // row: {exact expected, op, core}
   localparam logic [8:0] VEC [NROW] = '{
      {1'b1, CL, 6'd0},  {1'b1, AD, 6'd3},  {1'b1, AD, 6'd10}, {1'b1, AD, 6'd3},
      {1'b1, EX, 6'd0},  {1'b1, AD, 6'd40}, {1'b1, AD, 6'd63}, {1'b1, AD, 6'd0},
      {1'b1, AD, 6'd10}, {1'b1, EX, 6'd0},  {1'b0, AD, 6'd5},  {1'b0, EX, 6'd0},
      {1'b0, AD, 6'd6},  {1'b0, EX, 6'd0},  {1'b0, AD, 6'd20}, {1'b0, EX, 6'd0},
      {1'b1, CL, 6'd0},  {1'b1, EX, 6'd0},  {1'b1, AD, 6'd33}, {1'b1, EX, 6'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_s = 2'b00;
   logic [5:0]    core_s = '0;
   logic          exp_valid, exp_exact;
   logic [NC-1:0] exp_mask;
   logic [1:0]    op2 = 2'b00;
   logic [3:0]    core2 = '0;
   logic          v2, x2;
   logic [NC2-1:0] m2;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [NC-1:0] ref_set = '0;
   int ndist = 0;

   always #5 clk = ~clk;

   shr_rec_enc uut (
      .clk(clk), .rst_n(rst_n), .cmd_op(op_s), .cmd_core(core_s),
      .exp_valid(exp_valid), .exp_mask(exp_mask), .exp_exact(exp_exact));

   shr_rec_enc #(.NUM_CORES(NC2)) uut_small (
      .clk(clk), .rst_n(rst_n), .cmd_op(op2), .cmd_core(core2),
      .exp_valid(v2), .exp_mask(m2), .exp_exact(x2));

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [5:0] c);
      op_s = op; core_s = c;
      @(negedge clk);
      op_s = I_;
   endtask

   task automatic issue2(input logic [1:0] op, input logic [3:0] c);
      op2 = op; core2 = c;
      @(negedge clk);
      op2 = I_;
   endtask

   task automatic model(input logic [1:0] op, input logic [5:0] c);
      if (op == CL) begin
         ref_set = '0; ndist = 0;
      end else if (op == AD && !ref_set[c]) begin
         ref_set[c] = 1'b1; ndist++;
      end
   endtask

   function automatic logic [NC-1:0] expect_mask();
      logic [NC-1:0] m = '0;
      if (ndist <= NP) return ref_set;
      for (int c = 0; c < NC; c++) m[c] = |ref_set[(c/GS)*GS +: GS];
      return m;
   endfunction

   task automatic run(input logic [1:0] op, input logic [5:0] c, input string tag);
      logic [NC-1:0] em;
      issue(op, c);
      model(op, c);
      if (op == EX) begin
         em = expect_mask();
         chk(exp_valid == 1'b1, "R2 valid", 64'(exp_valid), 64'd1);
         chk(exp_mask == em, tag, exp_mask, em);
         chk((exp_mask & ref_set) == ref_set, "R7 superset", exp_mask, ref_set);
         chk(exp_exact == (ndist <= NP), "R5 exact flag", 64'(exp_exact), 64'(ndist <= NP));
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R2 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NC-1:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(exp_valid == 1'b0, "R1 valid", 64'(exp_valid), 64'd0);
      chk(exp_mask == '0, "R1 mask", exp_mask, 64'd0);
      run(EX, 6'd0, "R1 empty expand");
      chk(exp_exact == 1'b1, "R1 exact", 64'(exp_exact), 64'd1);

      // table walk
      for (int r = 0; r < NROW; r++) begin
         run(VEC[r][7:6], VEC[r][5:0], VEC[r][8] ? "R3 exact mask" : "R5/R6 coarse mask");
         if (VEC[r][7:6] == EX)
            chk(exp_exact == VEC[r][8], "R5 table flag", 64'(exp_exact), 64'(VEC[r][8]));
      end

      // R2: pulse lasts one cycle, mask holds across other commands
      held = exp_mask;
      issue(I_, 6'd0);
      chk(exp_valid == 1'b0, "R2 pulse end", 64'(exp_valid), 64'd0);
      issue(AD, 6'd60); model(AD, 6'd60);
      chk(exp_mask == held, "R2 mask hold", exp_mask, held);

      // R4: repeated adds of one core take one slot
      run(CL, 6'd0, "R8 clear");
      for (int k = 0; k < 6; k++) run(AD, 6'd7, "R4 dup");
      run(AD, 6'd8, "R4"); run(AD, 6'd9, "R4");
      run(AD, 6'd50, "R4"); run(AD, 6'd51, "R4");
      run(EX, 6'd0, "R4 dup exact mask");
      chk(exp_exact == 1'b1, "R4 still exact", 64'(exp_exact), 64'd1);

      // R5/R6: overflow, group-mate adds, sticky until clear
      run(AD, 6'd62, "R5 overflow");
      run(EX, 6'd0, "R5 converted mask");
      held = exp_mask;
      run(AD, 6'd61, "R6 group mate");
      run(EX, 6'd0, "R6 same group mask");
      chk(exp_mask == held, "R6 unchanged", exp_mask, held);
      run(AD, 6'd30, "R6 new group");
      run(EX, 6'd0, "R6 new group mask");
      chk(exp_exact == 1'b0, "R6 sticky", 64'(exp_exact), 64'd0);

      // R8: clear from coarse, exact again
      run(CL, 6'd0, "R8 clear");
      run(AD, 6'd1, "R8"); run(AD, 6'd2, "R8"); run(AD, 6'd44, "R8");
      run(EX, 6'd0, "R8 exact after clear");
      chk(exp_exact == 1'b1, "R8 flag", 64'(exp_exact), 64'd1);

      // R9: narrow variant keeps one bit per core
      begin
         logic [NC2-1:0] s2 = '0;
         foreach (VEC[i]) if (i < 10) begin
            logic [3:0] c = 4'((i * 7 + 1) % NC2);
            issue2(AD, c); s2[c] = 1'b1;
         end
         issue2(EX, 4'd0);
         chk(v2 == 1'b1, "R9 valid", 64'(v2), 64'd1);
         chk(m2 == s2, "R9 exact vector", 64'(m2), 64'(s2));
         chk(x2 == 1'b1, "R9 exact flag", 64'(x2), 64'd1);
         issue2(CL, 4'd0);
         issue2(EX, 4'd0);
         chk(m2 == '0, "R9 clear", 64'(m2), 64'd0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule